// File: doc/BRIEF.md
# Flash Sector Protection Register Unit

This block holds the protection state of every sector in a flash memory controller and enforces it. Each sector owns three control bits: one that hides its contents from array reads, one that bars program and erase, and a freeze bit that, once set, pins the other two until the next hardware reset. The host reaches the bits through a simple register select, write strobe and read-data path. The bus protocol decoding sits outside this block.

Array read data passes through the block. A sector whose read-hide bit is set returns all zeros. Program and erase requests also pass through the block. A request is either launched as a one-cycle strobe toward the array engine, or refused. A refusal sets a sticky sector-lock error flag. Two active-low protect pins can veto program and erase. One covers the highest sector and the other covers all remaining sectors. The pins never alter the stored bits, and they never appear in register readback.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector register reads 8'h01 (write-lock set, freeze and read-hide clear), lockErr is 0, busy is 0 and array data passes through unchanged.
- R2: The register layout is write-lock in bit 0, freeze in bit 1 and read-hide in bit 2. A write to an unfrozen sector loads all three bits from regWrData[2:0], and bits 7:3 always read as 0.
- R3: While the selected sector's read-hide bit is 1, arrDataOut is 8'h00, otherwise it equals arrDataIn. A hidden read never sets lockErr.
- R4: A request (opReq while not busy) to a sector whose write-lock bit is 1 raises no strobe, and lockErr is 1 after the next clock edge.
- R5: A permitted request raises progStb (opErase=0) or eraseStb (opErase=1) for exactly the cycle after the request edge, and sets busy until opDone. Requests made while busy are ignored, with no strobe and no error.
- R6: Write-lock is sampled only at the request edge. Setting it during a running operation neither aborts the operation nor flags an error, and it refuses the next request.
- R7: Once a sector's freeze bit is 1, every write to that sector's register is ignored, and its three bits keep their values.
- R8: The freeze bit is cleared only by rstN. After a reset the sector again reads 8'h01 and accepts writes.
- R9: With topProtN low, requests to sector NUM_SECTORS-1 are refused. With wpN low, requests to every other sector are refused. Neither pin changes or shows in register readback.
- R10: lockErr stays 1 until a clrStatus edge. When a refusal and clrStatus coincide, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset / power-up |
| regSel | input | SEC_W | Sector addressed by register read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register readback of the selected sector |
| arrSel | input | SEC_W | Sector of the current array read |
| arrDataIn | input | DATA_W | Raw array read data |
| arrDataOut | output | DATA_W | Array read data after read-hide masking |
| opReq | input | 1 | Program or erase request, one cycle |
| opErase | input | 1 | 1 = erase, 0 = program |
| opSel | input | SEC_W | Target sector of the request |
| opDone | input | 1 | Array engine reports the operation finished |
| clrStatus | input | 1 | Clear the sector-lock error flag |
| topProtN | input | 1 | Active-low protect for the highest sector |
| wpN | input | 1 | Active-low protect for all other sectors |
| progStb | output | 1 | One-cycle program launch strobe |
| eraseStb | output | 1 | One-cycle erase launch strobe |
| busy | output | 1 | An operation is running |
| lockErr | output | 1 | Sticky sector-lock error flag |

## Verification
The assertions assume that opReq lasts one cycle per request and that opDone arrives only while busy is high. They also assume that regSel, arrSel and opSel always name an existing sector. The directed stimulus holds to these limits. Every request is a single-cycle pulse, and opDone is pulsed only after a launch has been seen. All selects stay below NUM_SECTORS. A register write during a running operation is driven on purpose, because it is the case where write-lock is sampled at the request edge.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  localparam int REG_W  = 8;
  localparam int LOCK_W = 3;

  // Register write command handed from control to the lock file
  typedef struct packed {
    logic wrEn;
    logic hideRd;    // bit 2
    logic freeze;    // bit 1
    logic barWr;     // bit 0
  } lockCmd_t;
endpackage

// File: rtl/sguard_lockfile.sv
module sguard_lockfile
  import sguard_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int DATA_W      = 8,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lockCmd_t               cmd,
  input  logic [SEC_W-1:0]       regSel,
  output logic [REG_W-1:0]       regRdData,
  input  logic [SEC_W-1:0]       arrSel,
  input  logic [DATA_W-1:0]      arrDataIn,
  output logic [DATA_W-1:0]      arrDataOut,
  output logic [NUM_SECTORS-1:0] barWrVec
);
  logic [NUM_SECTORS-1:0] barWrQ;
  logic [NUM_SECTORS-1:0] freezeQ;
  logic [NUM_SECTORS-1:0] hideRdQ;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : gSector
    logic hit;
    assign hit = cmd.wrEn && (regSel == SEC_W'(g)) && !freezeQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        barWrQ[g]  <= 1'b1;
        freezeQ[g] <= 1'b0;
        hideRdQ[g] <= 1'b0;
      end else if (hit) begin
        barWrQ[g]  <= cmd.barWr;
        freezeQ[g] <= cmd.freeze;
        hideRdQ[g] <= cmd.hideRd;
      end
    end

    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      freezeQ[g] |=> freezeQ[g]);                                   // R8
    AST_FREEZE_HOLDS_BITS: assert property (@(posedge clk) disable iff (!rstN)
      freezeQ[g] |=> ($stable(barWrQ[g]) && $stable(hideRdQ[g])));  // R7
  end

  assign barWrVec   = barWrQ;
  assign regRdData  = {{(REG_W-LOCK_W){1'b0}}, hideRdQ[regSel], freezeQ[regSel], barWrQ[regSel]};
  assign arrDataOut = hideRdQ[arrSel] ? '0 : arrDataIn;

  AST_READBACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:LOCK_W] == '0);                               // R2
endmodule

// File: rtl/sguard_ctrl.sv
module sguard_ctrl
  import sguard_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [REG_W-1:0]       regWrData,
  output lockCmd_t               cmd,
  input  logic                   opReq,
  input  logic                   opErase,
  input  logic [SEC_W-1:0]       opSel,
  input  logic                   opDone,
  input  logic                   clrStatus,
  input  logic                   topProtN,
  input  logic                   wpN,
  input  logic [NUM_SECTORS-1:0] barWrVec,
  output logic                   progStb,
  output logic                   eraseStb,
  output logic                   busy,
  output logic                   lockErr
);
  localparam logic [SEC_W-1:0] TOP_SECTOR = SEC_W'(NUM_SECTORS - 1);

  logic unusedHigh;
  logic pinBlock;
  logic permit;
  logic accept;
  logic launch;
  logic refuse;

  assign unusedHigh = ^regWrData[REG_W-1:LOCK_W];

  assign cmd.wrEn   = regWrEn;
  assign cmd.barWr  = regWrData[0];
  assign cmd.freeze = regWrData[1];
  assign cmd.hideRd = regWrData[2];

  // Pins take precedence; the register bit is sampled here, at the request edge
  assign pinBlock = (opSel == TOP_SECTOR) ? !topProtN : !wpN;
  assign permit   = !barWrVec[opSel] && !pinBlock;
  assign accept   = opReq && !busy;
  assign launch   = accept && permit;
  assign refuse   = accept && !permit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      progStb  <= 1'b0;
      eraseStb <= 1'b0;
      lockErr  <= 1'b0;
    end else begin
      progStb  <= launch && !opErase;
      eraseStb <= launch && opErase;
      if (launch)      busy <= 1'b1;
      else if (opDone) busy <= 1'b0;
      if (refuse)         lockErr <= 1'b1;
      else if (clrStatus) lockErr <= 1'b0;
    end
  end

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !busy && barWrVec[opSel]) |=> lockErr);                       // R4
  AST_REFUSE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !busy && barWrVec[opSel]) |=> !(progStb || eraseStb));        // R4
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStb, eraseStb}));                                          // R5
  AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(progStb || eraseStb));                                        // R5
  AST_STROBE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (progStb || eraseStb) |-> busy);                                         // R5
  AST_PIN_VETO: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !busy && opSel == TOP_SECTOR && !topProtN) |=> !(progStb || eraseStb)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lockErr && !clrStatus) |=> lockErr);                                    // R10
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sguard_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int DATA_W      = 8,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEC_W-1:0]  regSel,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [SEC_W-1:0]  arrSel,
  input  logic [DATA_W-1:0] arrDataIn,
  output logic [DATA_W-1:0] arrDataOut,
  input  logic              opReq,
  input  logic              opErase,
  input  logic [SEC_W-1:0]  opSel,
  input  logic              opDone,
  input  logic              clrStatus,
  input  logic              topProtN,
  input  logic              wpN,
  output logic              progStb,
  output logic              eraseStb,
  output logic              busy,
  output logic              lockErr
);
  lockCmd_t               cmd;
  logic [NUM_SECTORS-1:0] barWrVec;

  sguard_ctrl #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .cmd(cmd),
    .opReq(opReq), .opErase(opErase), .opSel(opSel), .opDone(opDone),
    .clrStatus(clrStatus), .topProtN(topProtN), .wpN(wpN),
    .barWrVec(barWrVec),
    .progStb(progStb), .eraseStb(eraseStb), .busy(busy), .lockErr(lockErr)
  );

  sguard_lockfile #(.NUM_SECTORS(NUM_SECTORS), .DATA_W(DATA_W), .SEC_W(SEC_W)) uLocks (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .regSel(regSel), .regRdData(regRdData),
    .arrSel(arrSel), .arrDataIn(arrDataIn), .arrDataOut(arrDataOut),
    .barWrVec(barWrVec)
  );
endmodule

// File: tb/tb_sector_guard.sv
module tb_sector_guard;
  localparam int N  = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SW-1:0] regSel = '0, arrSel = '0, opSel = '0;
  logic regWrEn = 1'b0, opReq = 1'b0, opErase = 1'b0, opDone = 1'b0;
  logic clrStatus = 1'b0, topProtN = 1'b1, wpN = 1'b1;
  logic [7:0] regWrData = '0, arrDataIn = '0;
  logic [7:0] regRdData, arrDataOut;
  logic progStb, eraseStb, busy, lockErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sector_guard #(.NUM_SECTORS(N), .DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .arrSel(arrSel), .arrDataIn(arrDataIn), .arrDataOut(arrDataOut),
    .opReq(opReq), .opErase(opErase), .opSel(opSel), .opDone(opDone), .clrStatus(clrStatus),
    .topProtN(topProtN), .wpN(wpN), .progStb(progStb), .eraseStb(eraseStb),
    .busy(busy), .lockErr(lockErr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [SW-1:0] s, logic [7:0] d);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(string req, logic [SW-1:0] s, logic [7:0] exp);
    regSel = s;
    #1;
    chk(req, "regRdData", regRdData, exp);
  endtask

  // One request; checks launch or refusal and finishes a launched op
  task automatic issue(string req, logic [SW-1:0] s, logic er, bit ok);
    opSel = s; opErase = er; opReq = 1'b1;
    step();
    opReq = 1'b0;
    chk(req, "progStb", progStb, ok && !er);
    chk(req, "eraseStb", eraseStb, ok && er);
    chk(req, "busy", busy, ok);
    if (!ok) chk(req, "lockErr", lockErr, 1);
    if (ok) begin
      step();
      chk(req, "strobe width", progStb | eraseStb, 0);
      opDone = 1'b1;
      step();
      opDone = 1'b0;
      chk(req, "busy after done", busy, 0);
    end
  endtask

  task automatic clearErr(string req);
    clrStatus = 1'b1;
    step();
    clrStatus = 1'b0;
    chk(req, "lockErr cleared", lockErr, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) rdReg("R1", SW'(i), 8'h01);
    chk("R1", "lockErr", lockErr, 0);
    chk("R1", "busy", busy, 0);
    arrSel = 3'd6; arrDataIn = 8'h3C; #1;
    chk("R1", "arr passthrough", arrDataOut, 8'h3C);
  endtask

  task automatic t_layout();
    wrReg(3'd2, 8'hF4);
    rdReg("R2", 3'd2, 8'h04);
    wrReg(3'd3, 8'hF9);
    rdReg("R2", 3'd3, 8'h01);
  endtask

  task automatic t_readMask();
    arrSel = 3'd2; arrDataIn = 8'hA5; #1;
    chk("R3", "hidden read", arrDataOut, 8'h00);
    arrSel = 3'd3; #1;
    chk("R3", "open read", arrDataOut, 8'hA5);
    chk("R3", "no error from hidden read", lockErr, 0);
  endtask

  task automatic t_refuse();
    issue("R4", 3'd3, 1'b0, 1'b0);
    step(); step();
    chk("R10", "err sticky", lockErr, 1);
    clearErr("R10");
    opSel = 3'd3; opReq = 1'b1; clrStatus = 1'b1;
    step();
    opReq = 1'b0; clrStatus = 1'b0;
    chk("R10", "set beats clear", lockErr, 1);
    clearErr("R10");
  endtask

  task automatic t_launch();
    issue("R5", 3'd2, 1'b1, 1'b1);
    opSel = 3'd2; opErase = 1'b0; opReq = 1'b1;
    step();
    opReq = 1'b0;
    chk("R5", "progStb", progStb, 1);
    opSel = 3'd3; opErase = 1'b1; opReq = 1'b1;
    step();
    opReq = 1'b0;
    chk("R5", "busy request ignored strobe", progStb | eraseStb, 0);
    chk("R5", "busy request ignored err", lockErr, 0);
    opDone = 1'b1;
    step();
    opDone = 1'b0;
    chk("R5", "busy cleared", busy, 0);
  endtask

  task automatic t_sample();
    opSel = 3'd2; opErase = 1'b0; opReq = 1'b1;
    step();
    opReq = 1'b0;
    chk("R6", "launched", progStb, 1);
    wrReg(3'd2, 8'h05);
    chk("R6", "still busy", busy, 1);
    chk("R6", "no error mid-op", lockErr, 0);
    opDone = 1'b1;
    step();
    opDone = 1'b0;
    chk("R6", "done", busy, 0);
    issue("R6", 3'd2, 1'b0, 1'b0);
    clearErr("R6");
  endtask

  task automatic t_lockdown();
    wrReg(3'd4, 8'h02);
    rdReg("R7", 3'd4, 8'h02);
    wrReg(3'd4, 8'h05);
    rdReg("R7", 3'd4, 8'h02);
    issue("R7", 3'd4, 1'b0, 1'b1);
    wrReg(3'd5, 8'h07);
    wrReg(3'd5, 8'h00);
    rdReg("R7", 3'd5, 8'h07);
    arrSel = 3'd5; arrDataIn = 8'h5A; #1;
    chk("R7", "frozen hidden read", arrDataOut, 8'h00);
  endtask

  task automatic t_pins();
    wpN = 1'b0;
    issue("R9", 3'd4, 1'b0, 1'b0);
    rdReg("R9", 3'd4, 8'h02);
    clearErr("R9");
    wpN = 1'b1;
    wrReg(3'd7, 8'h00);
    topProtN = 1'b0;
    issue("R9", 3'd7, 1'b1, 1'b0);
    rdReg("R9", 3'd7, 8'h00);
    clearErr("R9");
    issue("R9", 3'd4, 1'b1, 1'b1);
    topProtN = 1'b1;
    issue("R9", 3'd7, 1'b0, 1'b1);
  endtask

  task automatic t_reset2();
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    step();
    rdReg("R8", 3'd4, 8'h01);
    rdReg("R8", 3'd5, 8'h01);
    wrReg(3'd4, 8'h00);
    rdReg("R8", 3'd4, 8'h00);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_layout();
    t_readMask();
    t_refuse();
    t_launch();
    t_sample();
    t_lockdown();
    t_pins();
    t_reset2();
    step();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule